// File: doc/BRIEF.md
# Periodic/Free-Running Timer Channel

This block is one 16-bit up-counting timer channel for a microcontroller peripheral. Software programs it over a simple register port with a write strobe, a read strobe, an address and a data word. A control word picks the count clock, the edge of that clock that advances the counter, and a compare register that resets the counter when they match. A run bit gates the counting. Out of reset the channel is a free-running counter with no reset source, and it waits for software to set the run bit.

The count clock is either the system clock itself, one of three divided ticks (divide by 4, 16 or 64), or an external pin that passes through a two-stage synchroniser. When a compare register is named as the reset source, the channel is periodic: it counts from 0 up to that register's value and then returns to 0. Compare matches and counter wraps set sticky status flags. Each flag has an enable bit, and the interrupt request is raised while any enabled flag is set. Software clears a flag by reading it as 1 and then writing 0 to it.

Top module: `tmr_channel`

## Requirements
- R1: After reset the counter reads 0, the control word reads 0 (free-running, divide-by-1, no reset source), the run bit, the status flags and the interrupt enables read 0, every compare register reads 0xFFFF, and `irq` is low.
- R2: The counter advances by one on each count edge while the run bit (address 1, bit 0) is 1. It holds its value while the run bit is 0. A write to address 4 loads the counter and takes priority over counting in that cycle.
- R3: Control bits [2:0] select the count clock: 0 is every system clock, 1, 2 and 3 divide it by 4, 16 and 64, and 4 to 7 select the `extClk` pin after a two-flop synchroniser.
- R4: Control bits [4:3] select the count edge of the divided or external tick: 00 counts rising edges, 01 counts falling edges, 1x counts both. With clock select 0 every system clock is a count edge, whatever the edge field holds.
- R5: Control bits [7:5] choose the reset source: value k from 1 to the number of compare registers selects compare register k-1 (address 8+k-1), and any other value selects none. On a count edge where the counter equals the selected register, the counter loads 0 instead of incrementing, so the period is that value plus one count edges.
- R6: On a count edge where the counter is 0xFFFF and no reset match occurs, the counter wraps to 0, status bit 0 is set, and counting continues from 0.
- R7: On a count edge where the counter equals compare register k, status bit k+1 is set. This happens in both free-running and periodic operation.
- R8: A status flag (address 3) is cleared only by a write of 0 to its bit after a read with `rdEn` that returned the bit as 1. Writing 1 leaves it unchanged. Writing 0 without that read leaves it set. If a set event falls in the same cycle as the clearing write, the flag stays set.
- R9: `irq` is high exactly while some status bit and its enable bit (address 2, same bit layout as status) are both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe; arms status flags for clearing |
| addr | input | 4 | Register address |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Read data for `addr` (combinational) |
| extClk | input | 1 | External count clock, asynchronous |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle the assertions check the counter's step behaviour: it holds when stopped, it increments by one on a count edge, it returns to zero on a reset match or a wrap, it raises the matching flag, a flag stays set unless status is written, and the interrupt stays quiet with no enabled flag. Only the bench scenarios can show the edge rates that come from the clock-select and edge-select combinations. They also show the length of the periodic cycle seen from the read port, the read-then-write clearing handshake, and the priority of a set event over a clearing write in the same cycle.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  // register addresses
  localparam int ADDR_CTRL   = 0;
  localparam int ADDR_RUN    = 1;
  localparam int ADDR_IEN    = 2;
  localparam int ADDR_STATUS = 3;
  localparam int ADDR_COUNT  = 4;
  localparam int ADDR_CMP0   = 8;

  // control word field positions
  localparam int CTRL_W      = 8;
  localparam int PRESC_LSB   = 0;
  localparam int EDGE_LSB    = 3;
  localparam int CLEAR_LSB   = 5;

  // control -> datapath strobes
  typedef struct packed {
    logic       run;
    logic       cntLoad;
    logic [2:0] prescSel;
    logic [1:0] edgeSel;
    logic [2:0] clearSel;
  } tmr_strobe_t;

endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int NUM_CMP = 4,
  parameter int ADDR_W  = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      wrEn,
  input  logic                      rdEn,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [CNT_W-1:0]          wrData,
  output logic [CNT_W-1:0]          rdData,
  input  logic [CNT_W-1:0]          cntVal,
  input  logic [NUM_CMP-1:0]        matchVec,
  input  logic                      ovfEvent,
  output tmr_strobe_t               strb,
  output logic [NUM_CMP*CNT_W-1:0]  cmpFlat,
  output logic [NUM_CMP:0]          flags,
  output logic [NUM_CMP:0]          ien
);

  localparam int FLAG_W = NUM_CMP + 1;

  logic [CTRL_W-1:0] ctrlReg;
  logic              runReg;
  logic [FLAG_W-1:0] ienReg;
  logic [FLAG_W-1:0] flagReg;
  logic [FLAG_W-1:0] armReg;

  logic wrCtrl, wrRun, wrIen, wrStatus, rdStatus;

  assign wrCtrl   = wrEn && (addr == ADDR_W'(ADDR_CTRL));
  assign wrRun    = wrEn && (addr == ADDR_W'(ADDR_RUN));
  assign wrIen    = wrEn && (addr == ADDR_W'(ADDR_IEN));
  assign wrStatus = wrEn && (addr == ADDR_W'(ADDR_STATUS));
  assign rdStatus = rdEn && (addr == ADDR_W'(ADDR_STATUS));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg <= '0;
      runReg  <= 1'b0;
      ienReg  <= '0;
    end else begin
      if (wrCtrl) ctrlReg <= wrData[CTRL_W-1:0];
      if (wrRun)  runReg  <= wrData[0];
      if (wrIen)  ienReg  <= wrData[FLAG_W-1:0];
    end
  end

  // compare registers
  for (genvar k = 0; k < NUM_CMP; k++) begin : g_cmp
    logic [CNT_W-1:0] cmpReg;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) cmpReg <= '1;
      else if (wrEn && (addr == ADDR_W'(ADDR_CMP0 + k))) cmpReg <= wrData;
    end
    assign cmpFlat[k*CNT_W +: CNT_W] = cmpReg;
  end

  // sticky flags: read-as-1 arms, write-0 clears, set wins
  logic [FLAG_W-1:0] setVec, clrVec;
  assign setVec = {matchVec, ovfEvent};
  assign clrVec = wrStatus ? (armReg & ~wrData[FLAG_W-1:0]) : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagReg <= '0;
      armReg  <= '0;
    end else begin
      flagReg <= (flagReg & ~clrVec) | setVec;
      if (wrStatus)      armReg <= '0;
      else if (rdStatus) armReg <= armReg | flagReg;
    end
  end

  // read mux
  always_comb begin
    rdData = '0;
    if (addr == ADDR_W'(ADDR_CTRL))   rdData = CNT_W'(ctrlReg);
    if (addr == ADDR_W'(ADDR_RUN))    rdData = CNT_W'(runReg);
    if (addr == ADDR_W'(ADDR_IEN))    rdData = CNT_W'(ienReg);
    if (addr == ADDR_W'(ADDR_STATUS)) rdData = CNT_W'(flagReg);
    if (addr == ADDR_W'(ADDR_COUNT))  rdData = cntVal;
    for (int k = 0; k < NUM_CMP; k++) begin
      if (addr == ADDR_W'(ADDR_CMP0 + k)) rdData = cmpFlat[k*CNT_W +: CNT_W];
    end
  end

  assign strb.run      = runReg;
  assign strb.cntLoad  = wrEn && (addr == ADDR_W'(ADDR_COUNT));
  assign strb.prescSel = ctrlReg[PRESC_LSB +: 3];
  assign strb.edgeSel  = ctrlReg[EDGE_LSB +: 2];
  assign strb.clearSel = ctrlReg[CLEAR_LSB +: 3];

  assign flags = flagReg;
  assign ien   = ienReg;

endmodule

// File: rtl/tmr_dp.sv
module tmr_dp
  import tmr_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int NUM_CMP     = 4,
  parameter int NUM_DIV     = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  tmr_strobe_t               strb,
  input  logic [CNT_W-1:0]          loadData,
  input  logic [NUM_CMP*CNT_W-1:0]  cmpFlat,
  input  logic                      extClk,
  output logic [CNT_W-1:0]          cntVal,
  output logic                      countEdge,
  output logic [NUM_CMP-1:0]        matchVec,
  output logic                      ovfEvent
);

  localparam int PRE_W = 2 * NUM_DIV;

  // free-running prescaler, taps divide by 4, 16, 64 ...
  logic [PRE_W-1:0]   preCnt;
  logic [NUM_DIV-1:0] tap;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) preCnt <= '0;
    else       preCnt <= preCnt + 1'b1;
  end

  for (genvar j = 0; j < NUM_DIV; j++) begin : g_tap
    assign tap[j] = preCnt[2*j+1];
  end

  // external clock synchroniser
  logic [SYNC_STAGES-1:0] syncQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[SYNC_STAGES-2:0], extClk};
  end

  // tick selection and edge detection
  logic tick, tickPrev, riseHit, fallHit, edgeHit;

  always_comb begin
    tick = syncQ[SYNC_STAGES-1];
    for (int j = 0; j < NUM_DIV; j++) begin
      if (strb.prescSel == 3'(j + 1)) tick = tap[j];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) tickPrev <= 1'b0;
    else       tickPrev <= tick;
  end

  assign riseHit = tick & ~tickPrev;
  assign fallHit = ~tick & tickPrev;
  assign edgeHit = strb.edgeSel[1] ? (riseHit | fallHit)
                 : strb.edgeSel[0] ? fallHit : riseHit;
  assign countEdge = (strb.prescSel == 3'd0) ? 1'b1 : edgeHit;

  // compare and clear
  logic [NUM_CMP-1:0] matchRaw;
  logic               clrHit, advance;

  for (genvar k = 0; k < NUM_CMP; k++) begin : g_match
    assign matchRaw[k] = (cntVal == cmpFlat[k*CNT_W +: CNT_W]);
  end

  always_comb begin
    clrHit = 1'b0;
    for (int k = 0; k < NUM_CMP; k++) begin
      if (strb.clearSel == 3'(k + 1)) clrHit = matchRaw[k];
    end
  end

  assign advance  = strb.run && countEdge && !strb.cntLoad;
  assign matchVec = advance ? matchRaw : '0;
  assign ovfEvent = advance && !clrHit && (&cntVal);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             cntVal <= '0;
    else if (strb.cntLoad) cntVal <= loadData;
    else if (advance)      cntVal <= clrHit ? '0 : cntVal + 1'b1;
  end

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int NUM_CMP = 4,
  parameter int ADDR_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wrData,
  output logic [CNT_W-1:0]  rdData,
  input  logic              extClk,
  output logic              irq
);

  tmr_strobe_t              strb;
  logic [CNT_W-1:0]         cntVal;
  logic                     countEdge;
  logic [NUM_CMP-1:0]       matchVec;
  logic                     ovfEvent;
  logic [NUM_CMP*CNT_W-1:0] cmpFlat;
  logic [NUM_CMP:0]         flags;
  logic [NUM_CMP:0]         ien;

  tmr_ctrl #(.CNT_W(CNT_W), .NUM_CMP(NUM_CMP), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .cntVal(cntVal), .matchVec(matchVec),
    .ovfEvent(ovfEvent), .strb(strb), .cmpFlat(cmpFlat), .flags(flags), .ien(ien)
  );

  tmr_dp #(.CNT_W(CNT_W), .NUM_CMP(NUM_CMP)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .loadData(wrData), .cmpFlat(cmpFlat),
    .extClk(extClk), .cntVal(cntVal), .countEdge(countEdge),
    .matchVec(matchVec), .ovfEvent(ovfEvent)
  );

  assign irq = |(flags & ien);

endmodule

// File: rtl/tmr_channel_chk.sv
module tmr_channel_chk
  import tmr_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int NUM_CMP = 4,
  parameter int ADDR_W  = 4
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     wrEn,
  input logic [ADDR_W-1:0]        addr,
  input tmr_strobe_t              strb,
  input logic [CNT_W-1:0]         cntVal,
  input logic                     countEdge,
  input logic [NUM_CMP*CNT_W-1:0] cmpFlat,
  input logic [NUM_CMP:0]         flags,
  input logic [NUM_CMP:0]         ien,
  input logic                     irq
);

  logic stepping, clrActive, statusWrite;

  assign stepping    = strb.run && !strb.cntLoad && countEdge;
  assign statusWrite = wrEn && (addr == ADDR_W'(ADDR_STATUS));

  always_comb begin
    clrActive = 1'b0;
    for (int k = 0; k < NUM_CMP; k++) begin
      if (strb.clearSel == 3'(k + 1) && cntVal == cmpFlat[k*CNT_W +: CNT_W]) clrActive = 1'b1;
    end
  end

  AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.run && !strb.cntLoad) |=> $stable(cntVal)); // R2

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (stepping && !clrActive && !(&cntVal)) |=> (cntVal == CNT_W'($past(cntVal) + 1'b1))); // R2

  AST_PERIOD_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (stepping && clrActive) |=> (cntVal == '0)); // R5

  AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (stepping && !clrActive && (&cntVal)) |=> (cntVal == '0 && flags[0])); // R6

  for (genvar k = 0; k < NUM_CMP; k++) begin : g_flag
    AST_MATCH_FLAG: assert property (@(posedge clk) disable iff (!rstN)
      (stepping && cntVal == cmpFlat[k*CNT_W +: CNT_W]) |=> flags[k+1]); // R7
  end

  for (genvar i = 0; i <= NUM_CMP; i++) begin : g_sticky
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
      (flags[i] && !statusWrite) |=> flags[i]); // R8
  end

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    ((flags & ien) == '0) |-> !irq); // R9

endmodule

bind tmr_channel tmr_channel_chk #(.CNT_W(CNT_W), .NUM_CMP(NUM_CMP), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .strb(strb), .cntVal(cntVal),
  .countEdge(countEdge), .cmpFlat(cmpFlat), .flags(flags), .ien(ien), .irq(irq)
);

// File: tb/tb_tmr_channel.sv
module tb_tmr_channel;

  localparam int CLK_PERIOD = 10;
  localparam int WIN        = 256;
  localparam int EXT_HALF   = 8;
  localparam int SEED       = 32'h5EED;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic        extClk = 1'b0;
  logic        irq;

  int checks = 0;
  int failures = 0;

  tmr_channel dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .extClk(extClk), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    forever begin
      repeat (EXT_HALF) @(negedge clk);
      extClk = ~extClk;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // all bus tasks start and end at a negedge
  task automatic busWrite(input int a, input logic [15:0] d);
    addr = 4'(a); wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic busRead(input int a, output logic [15:0] d);
    addr = 4'(a); rdEn = 1'b1;
    #1 d = rdData;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic peek(input int a, output logic [15:0] d);
    addr = 4'(a); rdEn = 1'b0;
    #1 d = rdData;
  endtask

  function automatic int edgesIn(input int presc, input int edgeMode, input int w);
    int div, n;
    if (presc == 0) return w;
    div = (presc >= 4) ? 2*EXT_HALF : (1 << (2*presc));
    n = w / div;
    return (edgeMode >= 2) ? 2*n : n;
  endfunction

  function automatic logic [15:0] modelCount(input logic [15:0] c, input int n,
                                             input logic [15:0] p, input bit clrOn);
    logic [15:0] v = c;
    for (int i = 0; i < n; i++) v = (clrOn && v == p) ? 16'd0 : v + 16'd1;
    return v;
  endfunction

  initial begin
    repeat (400000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    logic [15:0] d, c0, c1, expv;
    logic [15:0] cmpVals [4];
    int presc, edgeMode, clrSel, n;
    bit clrOn;
    logic [15:0] period;

    d = 16'($urandom(SEED));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // reset state
    peek(4, d);  check(d == 16'h0000, "R1", "count after reset", d, 0);
    peek(0, d);  check(d == 16'h0000, "R1", "control after reset", d, 0);
    peek(1, d);  check(d == 16'h0000, "R1", "run after reset", d, 0);
    peek(3, d);  check(d == 16'h0000, "R1", "status after reset", d, 0);
    peek(2, d);  check(d == 16'h0000, "R1", "enables after reset", d, 0);
    peek(8, d);  check(d == 16'hFFFF, "R1", "compare0 after reset", d, 16'hFFFF);
    check(irq == 1'b0, "R1", "irq after reset", irq, 0);
    repeat (20) @(negedge clk);
    peek(4, d);  check(d == 16'h0000, "R2", "count idle before start", d, 0);

    // random trials: rate over a fixed window
    for (int t = 0; t < 16; t++) begin
      busWrite(1, 16'd0);
      presc    = int'($urandom % 8);
      edgeMode = int'($urandom % 4);
      clrSel   = int'($urandom % 6);
      for (int k = 0; k < 4; k++) begin
        cmpVals[k] = 16'(40 + $urandom % 400);
        busWrite(8 + k, cmpVals[k]);
      end
      busWrite(0, 16'((clrSel << 5) | (edgeMode << 3) | presc));
      busWrite(4, 16'($urandom % 30));
      busWrite(1, 16'd1);
      repeat (70) @(negedge clk);
      clrOn  = (clrSel >= 1 && clrSel <= 4);
      period = clrOn ? cmpVals[clrSel-1] : 16'hFFFF;
      peek(4, c0);
      repeat (WIN) @(negedge clk);
      peek(4, c1);
      n = edgesIn(presc, edgeMode, WIN);
      expv = modelCount(c0, n, period, clrOn);
      check(c1 == expv, (clrOn ? "R5" : (presc >= 4 ? "R3" : "R4")),
            $sformatf("trial %0d presc=%0d edge=%0d clr=%0d", t, presc, edgeMode, clrSel),
            c1, expv);
    end

    // directed: divide-by-16 falling, external both edges
    busWrite(1, 16'd0);
    busWrite(0, 16'((2 << 0) | (1 << 3)));
    busWrite(1, 16'd1);
    repeat (70) @(negedge clk);
    peek(4, c0); repeat (WIN) @(negedge clk); peek(4, c1);
    check(16'(c1 - c0) == 16'(WIN/16), "R4", "div16 falling edge count", 16'(c1 - c0), WIN/16);
    busWrite(1, 16'd0);
    busWrite(0, 16'((5 << 0) | (2 << 3)));
    busWrite(1, 16'd1);
    repeat (70) @(negedge clk);
    peek(4, c0); repeat (WIN) @(negedge clk); peek(4, c1);
    check(16'(c1 - c0) == 16'(WIN/EXT_HALF), "R3", "external both-edge count", 16'(c1 - c0), WIN/EXT_HALF);

    // hold while stopped
    busWrite(1, 16'd0);
    peek(4, c0); repeat (50) @(negedge clk); peek(4, c1);
    check(c1 == c0, "R2", "count holds while stopped", c1, c0);

    // clear all flags, then overflow
    busWrite(0, 16'd0);
    busRead(3, d);
    busWrite(3, 16'd0);
    peek(3, d);  check(d == 16'h0000, "R8", "flags cleared after read/write0", d, 0);
    busWrite(2, 16'h0001);
    busWrite(4, 16'hFFFE);
    busWrite(1, 16'd1);
    repeat (5) @(negedge clk);
    busWrite(1, 16'd0);
    peek(4, d);  check(d == 16'h0004, "R6", "count continues after wrap", d, 4);
    peek(3, d);  check(d[0] == 1'b1, "R6", "overflow flag set", d[0], 1);
    check(irq == 1'b1, "R9", "irq with overflow enabled", irq, 1);

    // clear protocol
    busWrite(3, 16'h0000);
    peek(3, d);  check(d[0] == 1'b1, "R8", "write0 without read keeps flag", d[0], 1);
    busRead(3, d);
    busWrite(3, 16'h0001);
    peek(3, d);  check(d[0] == 1'b1, "R8", "write1 keeps flag", d[0], 1);
    busRead(3, d);
    busWrite(3, 16'h0000);
    peek(3, d);  check(d[0] == 1'b0, "R8", "read then write0 clears flag", d[0], 0);
    check(irq == 1'b0, "R9", "irq drops after clear", irq, 0);

    // compare flag in free-running mode, then set-wins
    busWrite(8, 16'h0100);
    busWrite(4, 16'h0100);
    busWrite(1, 16'd1);
    busWrite(1, 16'd0);
    peek(3, d);  check(d[1] == 1'b1, "R7", "compare0 flag in free-running mode", d[1], 1);
    busRead(3, d);
    busWrite(4, 16'h0100);
    busWrite(1, 16'd1);
    busWrite(3, 16'h0000);
    busWrite(1, 16'd0);
    peek(4, d);  check(d == 16'h0102, "R2", "count after two edges", d, 16'h0102);
    peek(3, d);  check(d[1] == 1'b1, "R8", "set wins over same-cycle clear", d[1], 1);
    busRead(3, d);
    busWrite(3, 16'h0000);
    peek(3, d);  check(d[1] == 1'b0, "R8", "compare0 flag cleared", d[1], 0);

    // periodic directed: compare2 = 5 selected by clear field 3
    busWrite(10, 16'd5);
    busWrite(0, 16'(3 << 5));
    busWrite(2, 16'h0008);
    busWrite(4, 16'd0);
    busWrite(1, 16'd1);
    peek(4, d);  check(d == 16'd0, "R5", "periodic count step 0", d, 0);
    for (int k = 1; k < 14; k++) begin
      @(negedge clk);
      peek(4, d);
      check(d == 16'(k % 6), "R5", $sformatf("periodic count step %0d", k), d, k % 6);
    end
    busWrite(1, 16'd0);
    peek(3, d);  check(d[3] == 1'b1, "R7", "compare2 flag in periodic mode", d[3], 1);
    check(irq == 1'b1, "R9", "irq from enabled compare2 flag", irq, 1);

    report();
  end

endmodule